// File: doc/BRIEF.md
# Palettized Pixel Scanout with Hardware Cursor

This block is the pixel pipeline of an 8-bit indexed-color display. A pair of raster counters walks a frame of programmable width and height. For every position the block issues a video memory address, which is the frame start offset plus the running pixel number. The byte that comes back is an index into a 256-entry table of 24-bit colors.

A 64x64 cursor with two bits per pixel is laid over the picture. Its pattern is kept as eight 16-bit words per cursor row, and its colors come from a separate three-entry table. The result is registered as a 24-bit RGB pixel with a valid strobe and an end-of-frame strobe. A sticky interrupt flags each finished frame.

The tables are loaded through simple write ports. The display configuration arrives as static inputs, which a register block outside this unit provides.

Top module: `pix_scanout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pix_valid`, `pix_eof`, `irq` and `pix_rgb` are all zero.
- R2: Pixels are produced in raster order: X runs from 0 to width-1, then Y advances. Pixel number n reads video memory at `cfg_start + n`, modulo 2^AW. The frame restarts at address `cfg_start` after its last pixel.
- R3: An uncovered pixel shows the color table entry selected by its memory byte. The color is packed as red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: A pixel is inside the cursor when `cur_x <= X < cur_x+64` and `cur_y <= Y < cur_y+64`. Its 2-bit code is taken from pattern word (Y-cur_y)*8 + (X-cur_x)/8, at bits starting at ((X-cur_x) mod 8)*2. Windows that are clipped by the frame edges are handled.
- R5: Code 0 is transparent. Codes 1, 2 and 3 select cursor color entries 0, 1 and 2. A cursor color write with index 3 is ignored.
- R6: When `cfg_cur_off` is 1, no pixel is covered by the cursor.
- R7: When `cfg_blank` is 1, every valid pixel is black (0). Valid and end-of-frame timing is unchanged.
- R8: Only mode code 3 (8 bits per pixel) produces pixels. With any other `cfg_mode` value, `pix_valid` stays low and no interrupt is raised.
- R9: A width or height of zero produces no pixels and no interrupt.
- R10: A pixel appears on the outputs exactly two cycles after its counter position is issued. For example, the first pixel is valid on the second clock edge after the frame is enabled. `pix_eof` marks only the last pixel of a frame.
- R11: `irq` goes high with the last pixel of every frame and stays high until `irq_clr` is sampled. If a frame end and a clear fall in the same cycle, the interrupt is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | XW | Frame width in pixels |
| cfg_height | input | XW | Frame height in lines |
| cfg_start | input | AW | Video memory offset of the first pixel |
| cfg_mode | input | 3 | Depth code; 3 selects 8 bits per pixel |
| cfg_blank | input | 1 | Force all pixels black |
| cfg_cur_off | input | 1 | Hide the cursor |
| cur_x | input | XW | Cursor left column |
| cur_y | input | XW | Cursor top line |
| pal_we | input | 1 | Color table write strobe |
| pal_idx | input | 8 | Color table entry |
| pal_rgb | input | 24 | Color table data |
| cpal_we | input | 1 | Cursor color write strobe |
| cpal_idx | input | 2 | Cursor color entry (0..2) |
| cpal_rgb | input | 24 | Cursor color data |
| pat_we | input | 1 | Cursor pattern write strobe |
| pat_idx | input | 2*CUR_LOG-3 | Cursor pattern word index |
| pat_word | input | 16 | Cursor pattern word |
| irq_clr | input | 1 | Clear the frame interrupt |
| vram_addr | output | AW | Video memory read address |
| vram_data | input | 8 | Byte for the previous cycle's address |
| pix_valid | output | 1 | Pixel strobe |
| pix_rgb | output | 24 | Pixel color |
| pix_eof | output | 1 | Last pixel of the frame |
| irq | output | 1 | Frame-done interrupt |

## Verification
The bench keeps XW=12 and CUR_LOG=6, and shrinks AW to 14. With a 16 KiB memory model, a start offset close to the top of the address space shows the read address wrapping within one short frame. Frames of 80x70 and 70x66 are small enough to run whole frames. They are still large enough for a full 64x64 cursor window, including windows clipped on the right and at the bottom edge. They also include the last cursor row. A 1x1 frame exercises a frame end on every pixel.

// File: rtl/pix_scanout.sv
module pix_scanout #(
  parameter int XW      = 12,
  parameter int AW      = 23,
  parameter int CUR_LOG = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XW-1:0]        cfg_width,
  input  logic [XW-1:0]        cfg_height,
  input  logic [AW-1:0]        cfg_start,
  input  logic [2:0]           cfg_mode,
  input  logic                 cfg_blank,
  input  logic                 cfg_cur_off,
  input  logic [XW-1:0]        cur_x,
  input  logic [XW-1:0]        cur_y,
  input  logic                 pal_we,
  input  logic [7:0]           pal_idx,
  input  logic [23:0]          pal_rgb,
  input  logic                 cpal_we,
  input  logic [1:0]           cpal_idx,
  input  logic [23:0]          cpal_rgb,
  input  logic                 pat_we,
  input  logic [2*CUR_LOG-4:0] pat_idx,
  input  logic [15:0]          pat_word,
  input  logic                 irq_clr,
  output logic [AW-1:0]        vram_addr,
  input  logic [7:0]           vram_data,
  output logic                 pix_valid,
  output logic [23:0]          pix_rgb,
  output logic                 pix_eof,
  output logic                 irq
);
  localparam int PW = 2*CUR_LOG-3;
  localparam int CUR = 1 << CUR_LOG;
  localparam logic [XW-1:0] CUR_SPAN = XW'(CUR);
  localparam logic [2:0] MODE_8BPP = 3'd3;

  logic [23:0] pal  [256];
  logic [23:0] cpal [3];
  logic [15:0] pat  [1<<PW];

  always_ff @(posedge clk) begin
    if (pal_we) pal[pal_idx] <= pal_rgb;
    if (pat_we) pat[pat_idx] <= pat_word;
  end

  for (genvar g = 0; g < 3; g++) begin : g_cpal
    always_ff @(posedge clk)
      if (cpal_we && cpal_idx == 2'(g)) cpal[g] <= cpal_rgb;
  end

  logic [XW-1:0] x0, y0, x1, y1;
  logic [AW-1:0] lin;
  logic          v1, e1;

  wire run    = (cfg_width != '0) && (cfg_height != '0) && (cfg_mode == MODE_8BPP);
  wire x_last = (x0 == cfg_width - XW'(1));
  wire y_last = (y0 == cfg_height - XW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0 <= '0; y0 <= '0; lin <= '0;
      x1 <= '0; y1 <= '0; v1 <= 1'b0; e1 <= 1'b0;
    end else begin
      v1 <= run;
      e1 <= run && x_last && y_last;
      x1 <= x0;
      y1 <= y0;
      if (!run || (x_last && y_last)) begin
        x0 <= '0; y0 <= '0; lin <= '0;
      end else begin
        lin <= lin + AW'(1);
        if (x_last) begin
          x0 <= '0;
          y0 <= y0 + XW'(1);
        end else begin
          x0 <= x0 + XW'(1);
        end
      end
    end
  end

  assign vram_addr = cfg_start + lin;

  wire [XW-1:0] dx = x1 - cur_x;
  wire [XW-1:0] dy = y1 - cur_y;
  wire hit = !cfg_cur_off && (x1 >= cur_x) && (dx < CUR_SPAN)
                          && (y1 >= cur_y) && (dy < CUR_SPAN);
  wire [15:0] cword = pat[{dy[CUR_LOG-1:0], dx[CUR_LOG-1:3]}];
  wire [1:0]  code  = 2'(cword >> {dx[2:0], 1'b0});
  wire [23:0] rgb1  = cfg_blank ? 24'd0
                    : (hit && code != 2'd0) ? cpal[code - 2'd1]
                    : pal[vram_data];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_eof   <= 1'b0;
      pix_rgb   <= '0;
      irq       <= 1'b0;
    end else begin
      pix_valid <= v1;
      pix_eof   <= e1;
      pix_rgb   <= v1 ? rgb1 : 24'd0;
      if (e1)           irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end
endmodule

module pix_scanout_chk #(
  parameter int XW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XW-1:0] cfg_width,
  input logic [XW-1:0] cfg_height,
  input logic [2:0]    cfg_mode,
  input logic          cfg_blank,
  input logic          irq_clr,
  input logic          pix_valid,
  input logic [23:0]   pix_rgb,
  input logic          pix_eof,
  input logic          irq
);
  p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(cfg_blank)) |-> (pix_rgb == 24'd0));

  p_eof_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |-> pix_valid);

  p_mode_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_mode, 2) != 3'd3) |-> !pix_valid);

  p_zero_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_width == '0 || cfg_height == '0, 2)) |-> !pix_valid);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> pix_eof);

  p_eof_sets_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |-> irq);
endmodule

bind pix_scanout pix_scanout_chk #(.XW(XW)) u_chk (.*);

// File: tb/test_pix_scanout.sv
module test_pix_scanout;
  localparam int XW = 12, AW = 14, CUR_LOG = 6;
  localparam int MSZ = 1 << AW;
  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {12'd80, 12'd70, 14'd0,     12'd10, 12'd3,  1'b0, 1'b0, 3'd3},
    {12'd80, 12'd70, 14'd100,   12'd40, 12'd20, 1'b0, 1'b0, 3'd3},
    {12'd80, 12'd70, 14'd100,   12'd40, 12'd20, 1'b1, 1'b0, 3'd3},
    {12'd80, 12'd70, 14'd0,     12'd10, 12'd3,  1'b0, 1'b1, 3'd3},
    {12'd16, 12'd4,  14'd16380, 12'd0,  12'd0,  1'b0, 1'b0, 3'd3},
    {12'd80, 12'd70, 14'd0,     12'd10, 12'd3,  1'b0, 1'b0, 3'd2},
    {12'd0,  12'd70, 14'd0,     12'd0,  12'd0,  1'b0, 1'b0, 3'd3},
    {12'd80, 12'd0,  14'd0,     12'd0,  12'd0,  1'b0, 1'b0, 3'd3},
    {12'd1,  12'd1,  14'd5,     12'd0,  12'd0,  1'b0, 1'b0, 3'd3},
    {12'd70, 12'd66, 14'd300,   12'd6,  12'd1,  1'b0, 1'b0, 3'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [XW-1:0] cfg_width = '0, cfg_height = '0, cur_x = '0, cur_y = '0;
  logic [AW-1:0] cfg_start = '0;
  logic [2:0] cfg_mode = 3'd3;
  logic cfg_blank = 1'b0, cfg_cur_off = 1'b0;
  logic pal_we = 1'b0, cpal_we = 1'b0, pat_we = 1'b0, irq_clr = 1'b0;
  logic [7:0] pal_idx = '0;
  logic [1:0] cpal_idx = '0;
  logic [2*CUR_LOG-4:0] pat_idx = '0;
  logic [23:0] pal_rgb = '0, cpal_rgb = '0;
  logic [15:0] pat_word = '0;
  logic [AW-1:0] vram_addr;
  logic [7:0] vram_data = '0;
  logic pix_valid, pix_eof, irq;
  logic [23:0] pix_rgb;
  logic [7:0] mem [MSZ];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pix_scanout #(.XW(XW), .AW(AW), .CUR_LOG(CUR_LOG)) i_pix_scanout (.*);

  always @(posedge clk) vram_data <= mem[vram_addr];

  function automatic logic [23:0] pal_f(int i);
    return {8'(i), 8'(255 - i), 8'(i * 5 + 1)};
  endfunction
  function automatic logic [23:0] cpal_f(int k);
    return 24'h13579b + 24'(k) * 24'h212121;
  endfunction
  function automatic logic [15:0] pat_f(int k);
    return 16'(k * 40503 + 12345);
  endfunction

  function automatic logic [23:0] exp_px(int n, int w, int st, int cx, int cy, bit coff, bit blk);
    int x, y, dx, dy, c;
    logic [15:0] wd;
    x = n % w; y = n / w; dx = x - cx; dy = y - cy;
    if (blk) return 24'd0;
    if (!coff && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
      wd = pat_f(dy * 8 + dx / 8);
      c = int'((wd >> ((dx % 8) * 2)) & 16'd3);
      if (c != 0) return cpal_f(c - 1);
    end
    return pal_f(int'(mem[(st + n) % MSZ]));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] vw, vh, vcx, vcy;
    logic [13:0] vst;
    logic vco, vbl;
    logic [2:0] vmd;
    int n, bad, T;
    bit eof_seen, eof_bad, on;
    logic [23:0] fa, fe;

    for (int i = 0; i < MSZ; i++) mem[i] = 8'(i * 37 + (i >> 7));

    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    chk(pix_valid == 0 && irq == 0 && pix_eof == 0 && pix_rgb == 0, "R1 reset", {pix_valid, irq, pix_eof}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 0 && irq == 0 && pix_rgb == 0, "R1 after reset", {pix_valid, irq}, 0);

    for (int i = 0; i < 256; i++) begin
      pal_we = 1; pal_idx = 8'(i); pal_rgb = pal_f(i); @(negedge clk);
    end
    pal_we = 0;
    for (int i = 0; i < 512; i++) begin
      pat_we = 1; pat_idx = 9'(i); pat_word = pat_f(i); @(negedge clk);
    end
    pat_we = 0;
    for (int k = 0; k < 3; k++) begin
      cpal_we = 1; cpal_idx = 2'(k); cpal_rgb = cpal_f(k); @(negedge clk);
    end
    // R5: index 3 write must not disturb entries 0..2 (seen in frames below)
    cpal_idx = 2'd3; cpal_rgb = 24'hdead00; @(negedge clk);
    cpal_we = 0;

    for (int s = 0; s < NV; s++) begin
      {vw, vh, vst, vcx, vcy, vco, vbl, vmd} = VEC[s];
      on = (vmd == 3'd3) && vw != 0 && vh != 0;
      cfg_width = vw; cfg_height = vh; cfg_start = vst; cur_x = vcx; cur_y = vcy;
      cfg_cur_off = vco; cfg_blank = vbl; cfg_mode = vmd;
      n = 0; bad = 0; eof_seen = 0; eof_bad = 0; fa = 0; fe = 0;
      for (int c = 0; c < (on ? int'(vw) * int'(vh) + 10 : 20) && !eof_seen; c++) begin
        @(negedge clk);
        if (pix_valid) begin
          if (pix_rgb != exp_px(n, vw, vst, vcx, vcy, vco, vbl)) begin
            if (bad == 0) begin fa = pix_rgb; fe = exp_px(n, vw, vst, vcx, vcy, vco, vbl); end
            bad++;
          end
          if (pix_eof) begin
            eof_seen = 1;
            if (n != int'(vw) * int'(vh) - 1) eof_bad = 1;
          end
          n++;
        end
      end
      cfg_width = '0;
      // R3 R4 R5 R6 R7: pixel colors over the whole frame
      chk(bad == 0, $sformatf("R3/R4/R5/R6/R7 pixel colors vec %0d", s), fa, fe);
      // R2 R8 R9: pixel count per frame
      chk(n == (on ? int'(vw) * int'(vh) : 0), $sformatf("R2/R8/R9 pixel count vec %0d", s), n, on ? int'(vw) * int'(vh) : 0);
      // R10: end of frame on the last pixel only
      chk(!eof_bad && eof_seen == on, $sformatf("R10 eof placement vec %0d", s), eof_seen, on);
      // R11: interrupt follows frame end
      chk(irq == on, $sformatf("R11 irq vec %0d", s), irq, on);
      repeat (4) @(negedge clk);
      pulse_clr();
    end

    // R10 R2: latency and first address, R11 collision with clear
    cfg_mode = 3'd3; cfg_blank = 0; cfg_cur_off = 1;
    @(negedge clk);
    cfg_start = 14'd7; cfg_height = 12'd2; cfg_width = 12'd4;
    #1;
    chk(vram_addr == 14'd7, "R2 first address", vram_addr, 7);
    T = 0;
    @(negedge clk);
    chk(pix_valid == 0, "R10 not yet valid", pix_valid, 0);
    @(negedge clk);
    chk(pix_valid == 1 && pix_rgb == pal_f(int'(mem[7])), "R10 valid after two edges", pix_rgb, pal_f(int'(mem[7])));
    repeat (6) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    cfg_width = '0;
    chk(pix_eof == 1, "R10 eof at pixel 7", pix_eof, 1);
    chk(irq == 1, "R11 set wins over clear", irq, 1);
    repeat (20) @(negedge clk);
    chk(irq == 1, "R11 held without clear", irq, 1);
    pulse_clr();
    chk(irq == 0, "R11 cleared", irq, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule